// File: doc/BRIEF.md
# Expansion-Slot Flash Bus Responder

This block is a small slave for an asynchronous 32-bit processor bus. It sits behind an expansion slot and gives the host read and write access to a socketed flash module. The flash command sequences, the data path and the programming supply are handled elsewhere. The block samples the address strobe, the read/write line and a few upper address lines on its own clock. It decodes a fixed memory window from those lines. For each cycle inside the window, it drives the flash output-enable or write-enable strobe. After a fixed number of wait states it returns the two data-size acknowledge lines, both low, which marks a 32-bit port.

The wait-state count is a build parameter. A slow, compatibility-clocked slot can run with no wait states. A fast direct processor slot needs a few clocks of delay so that the flash access time is met. The block also drives the top address bit of the flash module from a two-bit bank mode. The bit can be held low, held high, copied from bus line A22, or copied inverted from A22. With a copied mode, the host can boot from one half of the module and program the other half.

Top module: `flash_slot_responder`

## Requirements
- R1: A cycle is served only when `addr_hi` equals `WIN_BASE` (default 4'hE) on the clock edge that first samples `as_n` low. For any other address, `oe_n`, `we_n`, `dsack1_n` and `dsack0_n` all stay high for the whole cycle.
- R2: In a served cycle, `rw`=1 (read) drives `oe_n` low and `rw`=0 (write) drives `we_n` low. The strobe goes low from the edge that starts the cycle. `oe_n` and `we_n` are never low at the same time.
- R3: `dsack1_n` and `dsack0_n` always carry the same value. In a served cycle they go low `WAIT_STATES` clock edges after the start edge. They stay low for as long as `as_n` is held low.
- R4: `WAIT_STATES` ranges from 0 to 7. With 0, the acknowledge appears on the same edge as the strobe. With 7, it appears seven edges later.
- R5: On the first clock edge that samples `as_n` high, the strobe and both acknowledge lines return high. This includes a cycle that the master ends before the acknowledge arrives, in which case no acknowledge is given at all.
- R6: `flash_top` follows `bank_mode` combinationally. Mode 0 gives 0. Mode 1 gives `a22`. Mode 2 gives the inverse of `a22`. Mode 3 gives 1.
- R7: While `rst_n` is low, `oe_n`, `we_n`, `dsack1_n` and `dsack0_n` are high.
- R8: The cycle direction is captured on the start edge. A change on `rw` while `as_n` stays low does not change which strobe is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Responder clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_n | input | 1 | Bus address strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr_hi | input | WIN_BITS | Upper address lines used for window decode |
| a22 | input | 1 | Bus address line A22 |
| bank_mode | input | 2 | Top flash address bit source |
| oe_n | output | 1 | Flash output enable, active low |
| we_n | output | 1 | Flash write enable, active low |
| dsack1_n | output | 1 | Data-size acknowledge, upper |
| dsack0_n | output | 1 | Data-size acknowledge, lower |
| flash_top | output | 1 | Top address bit to the flash module |

## Verification
The hardest case to reach is a cycle that the master ends before the acknowledge arrives. It only shows up with a long wait-state setting. The bench runs three copies of the block with 0, 2 and 7 wait states on one shared bus. It negates the strobe after three clocks, while the slowest copy is still counting. It then checks that this copy never acknowledges, and that the copy with 2 wait states had already answered. Flipping the direction line in the middle of a cycle, and starting a new cycle right after a release, cover the capture and re-arm paths.

// File: rtl/flash_slot_responder.sv
module flash_slot_responder #(
  parameter int WIN_BITS    = 4,
  parameter logic [WIN_BITS-1:0] WIN_BASE = 4'hE,
  parameter int WAIT_STATES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                as_n,
  input  logic                rw,
  input  logic [WIN_BITS-1:0] addr_hi,
  input  logic                a22,
  input  logic [1:0]          bank_mode,
  output logic                oe_n,
  output logic                we_n,
  output logic                dsack1_n,
  output logic                dsack0_n,
  output logic                flash_top
);
  localparam int CW = 3;
  localparam logic [CW-1:0] WAIT_LIM = CW'(WAIT_STATES);

  logic          busy, is_rd, ack;
  logic [CW-1:0] cnt;
  wire           hit = (addr_hi == WIN_BASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      is_rd <= 1'b1;
      ack   <= 1'b0;
      cnt   <= '0;
    end else if (!busy) begin
      if (!as_n && hit) begin
        busy  <= 1'b1;
        is_rd <= rw;
        cnt   <= '0;
        ack   <= (WAIT_LIM == '0);
      end
    end else if (as_n) begin
      busy <= 1'b0;
      ack  <= 1'b0;
    end else if (!ack) begin
      cnt <= cnt + 1'b1;
      ack <= ((cnt + 1'b1) == WAIT_LIM);
    end
  end

  assign oe_n     = ~(busy & is_rd);
  assign we_n     = ~(busy & ~is_rd);
  assign dsack1_n = ~ack;
  assign dsack0_n = ~ack;
  assign flash_top = bank_mode[1] ? (bank_mode[0] | ~a22) : (bank_mode[0] & a22);
endmodule

module flash_slot_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       as_n,
  input logic [1:0] bank_mode,
  input logic       oe_n,
  input logic       we_n,
  input logic       dsack1_n,
  input logic       dsack0_n,
  input logic       flash_top
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) oe_n || we_n); // R2
  AST_ACK_PAIR: assert property (@(posedge clk) disable iff (!rst_n) dsack1_n == dsack0_n); // R3
  AST_ACK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !dsack0_n |-> (!oe_n || !we_n)); // R3
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) as_n |=> (oe_n && we_n && dsack0_n && dsack1_n)); // R5
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!dsack0_n && !as_n) |=> !dsack0_n); // R3
  AST_BANK_LOW: assert property (@(posedge clk) disable iff (!rst_n) (bank_mode == 2'd0) |-> !flash_top); // R6
  AST_BANK_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (bank_mode == 2'd3) |-> flash_top); // R6
  always_comb if (!rst_n) AST_RESET_IDLE: assert (oe_n && we_n && dsack0_n && dsack1_n); // R7
endmodule

bind flash_slot_responder flash_slot_checks u_chk (.*);

// File: tb/sim_flash_slot_responder.sv
module sim_flash_slot_responder;
  logic clk = 1'b0, rst_n = 1'b0, as_n = 1'b1, rw = 1'b1, a22 = 1'b0;
  logic [3:0] addr_hi = 4'h0;
  logic [1:0] bank_mode = 2'd0;
  logic [2:0] oe_n, we_n, ds1, ds0, top;
  int vecs = 0, errs = 0;

  always #4 clk = ~clk;

  flash_slot_responder #(.WAIT_STATES(2)) u0 (.clk, .rst_n, .as_n, .rw, .addr_hi, .a22, .bank_mode,
    .oe_n(oe_n[0]), .we_n(we_n[0]), .dsack1_n(ds1[0]), .dsack0_n(ds0[0]), .flash_top(top[0]));
  flash_slot_responder #(.WAIT_STATES(0)) u1 (.clk, .rst_n, .as_n, .rw, .addr_hi, .a22, .bank_mode,
    .oe_n(oe_n[1]), .we_n(we_n[1]), .dsack1_n(ds1[1]), .dsack0_n(ds0[1]), .flash_top(top[1]));
  flash_slot_responder #(.WAIT_STATES(7)) u2 (.clk, .rst_n, .as_n, .rw, .addr_hi, .a22, .bank_mode,
    .oe_n(oe_n[2]), .we_n(we_n[2]), .dsack1_n(ds1[2]), .dsack0_n(ds0[2]), .flash_top(top[2]));

  localparam int WS [3] = '{2, 0, 7};
  // vector: [7:4] addr_hi, [3] rw, [2:1] bank_mode, [0] a22
  localparam int NV = 10;
  localparam logic [7:0] VEC [NV] = '{
    8'hE9, 8'hE3, 8'hEC, 8'hE6, 8'h3A, 8'hF5, 8'hEA, 8'h00, 8'hEF, 8'hD8 };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_cycle(input logic [3:0] a, input logic r, input int hold, input bit flip_rw);
    int first [3];
    bit lost [3];
    bit hit = (a == 4'hE);
    first = '{0, 0, 0};
    lost = '{0, 0, 0};
    addr_hi = a; rw = r; as_n = 1'b0;
    for (int k = 1; k <= hold; k++) begin
      @(negedge clk);
      if (k == 1 && flip_rw) rw = ~r;
      for (int i = 0; i < 3; i++) begin
        chk(ds0[i] == ds1[i], "R3 pair", ds1[i], ds0[i]);
        chk(oe_n[i] == !(hit && r), "R2 oe", oe_n[i], !(hit && r));
        chk(we_n[i] == !(hit && !r), "R2 we", we_n[i], !(hit && !r));
        if (!ds0[i] && first[i] == 0) first[i] = k;
        if (ds0[i] && first[i] != 0) lost[i] = 1;
      end
    end
    for (int i = 0; i < 3; i++) begin
      int exp = (hit && WS[i] + 1 <= hold) ? WS[i] + 1 : 0;
      chk(first[i] == exp, hit ? "R4 ack delay" : "R1 no ack outside", first[i], exp);
      chk(!lost[i], "R3 ack hold", lost[i], 0);
    end
    as_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 3; i++)
      chk(oe_n[i] && we_n[i] && ds0[i] && ds1[i], "R5 release", {oe_n[i], we_n[i], ds0[i]}, 7);
  endtask

  initial begin
    #3000000;
    errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    as_n = 1'b0; addr_hi = 4'hE;
    @(negedge clk);
    for (int i = 0; i < 3; i++)
      chk(oe_n[i] && we_n[i] && ds0[i] && ds1[i], "R7 reset idle", {oe_n[i], we_n[i], ds0[i]}, 7);
    as_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] e = VEC[v];
      logic expt;
      bank_mode = e[2:1]; a22 = e[0];
      case (e[2:1])
        2'd0: expt = 1'b0;
        2'd1: expt = e[0];
        2'd2: expt = ~e[0];
        default: expt = 1'b1;
      endcase
      #1;
      for (int i = 0; i < 3; i++) chk(top[i] == expt, "R6 bank", top[i], expt);
      run_cycle(e[7:4], e[3], 10, 1'b0);
    end

    for (int m = 0; m < 4; m++)
      for (int b = 0; b < 2; b++) begin
        bank_mode = 2'(m); a22 = b[0];
        #1;
        chk(top[0] == ((m == 0) ? 1'b0 : (m == 1) ? b[0] : (m == 2) ? ~b[0] : 1'b1),
            "R6 bank sweep", top[0], m * 2 + b);
      end

    // R8: rw flips mid-cycle, strobe must stay as captured
    run_cycle(4'hE, 1'b1, 9, 1'b1);
    run_cycle(4'hE, 1'b0, 9, 1'b1);

    // R5: early negation, before the slow copy acknowledges
    run_cycle(4'hE, 1'b1, 3, 1'b0);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(ds0[2] && oe_n[2], "R5 no late ack", ds0[2], 1);
    end

    // back-to-back cycles with a single idle clock
    run_cycle(4'hE, 1'b0, 4, 1'b0);
    run_cycle(4'hE, 1'b1, 4, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule